// File: doc/BRIEF.md
# SWD Host Transaction Engine

This block is the host side of a two-wire serial debug link. It drives the debug clock pin and a bidirectional data pin, whose output enable it controls. It runs one complete 32-bit register transfer per command, to either the debug port or an access port. A transfer covers the request header with its parity bit, the target's three-bit acknowledge, the turnaround cycles, the data phase with its parity bit, and the trailing idle clocks. A separate initialise command sends the long line-reset bursts and the 16-bit switch pattern that moves a target from its scan-chain protocol to the two-wire protocol.

A controller in the system presents a command with `cmdValid` while `busy` is low. It then waits for the one-cycle `done` pulse. At that pulse it reads the result code on `status` and, for reads, the data word on `rdata`. Both stay unchanged until the next command is accepted. The parameter `HALF_DIV` sets how many system clocks each half of a debug-clock period lasts.

Top module: `swd_host`

## Requirements
- R1: An initialise command (`cmdInit`=1) sends 336 driven bits in this order: 64 ones, 64 zeros, 64 ones, the 16-bit value 0x79E7 most significant bit first, 64 ones, then 64 zeros. It then reports status 0.
- R2: A transfer starts with 8 driven header bits in this order: 1, `cmdApNdp`, `cmdRnw`, `cmdAddr[0]`, `cmdAddr[1]`, the XOR of those four fields, 0, 1.
- R3: SWDIO output and output enable change only while SWCLK is low. SWCLK is high for exactly `HALF_DIV` system clocks per bit. The host samples input bits as SWCLK falls. SWCLK is low whenever the block is idle.
- R4: The three acknowledge bits, in received order, give the status. 1,0,0 gives OK (code 0). 0,1,0 gives WAIT (code 1). 0,0,1 gives FAULT (code 2). Any other pattern gives protocol error (code 3). A code other than OK skips the data phase.
- R5: A read with an OK acknowledge receives 32 data bits least significant first and then one parity bit. `rdata` holds the word. If the XOR of the data differs from the parity bit, the status is parity error (code 4). A read that is aborted returns `rdata` = 0.
- R6: After the parity bit of a read, or after the acknowledge of an aborted read, the host releases the line for one turnaround bit. It then drives 16 idle bits low.
- R7: A write releases the line for 5 bits: turnaround, the acknowledge, and turnaround. On OK it then drives 32 data bits least significant first, the even parity bit (the XOR of the data), and 15 low idle bits. On any other acknowledge it drives only the 15 idle bits.
- R8: With `cmdIgnoreAck`=1 on a write, the data phase always follows and the status is 0. On a read the option has no effect.
- R9: The output enable is low during every bit the target drives, including the turnaround bits, and high during every host-driven bit and while the block is idle.
- R10: `busy` is high from the cycle after a command is accepted until `done`. `done` lasts one cycle, and `busy` is low during it. `cmdValid` while busy is ignored.
- R11: `status` and `rdata` stay unchanged while the block is idle.
- R12: After reset `busy`, `done`, SWCLK and SWDIO are 0, the output enable is 1, and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command request, taken when not busy |
| cmdInit | input | 1 | 1 selects the initialise and switch sequence |
| cmdApNdp | input | 1 | 1 selects an access port, 0 the debug port |
| cmdRnw | input | 1 | 1 read, 0 write |
| cmdAddr | input | 2 | Register address bits 3:2 |
| cmdWdata | input | 32 | Write data |
| cmdIgnoreAck | input | 1 | Write proceeds whatever the acknowledge |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Last read data |
| status | output | 3 | Result code, 0..4 |
| swclk | output | 1 | Debug clock pin |
| swdioOut | output | 1 | Data pin output value |
| swdioOe | output | 1 | Data pin output enable |
| swdioIn | input | 1 | Data pin input value |

## Verification
A stuck or wrongly advanced phase counter changes the bit stream within one bit period. A bit is added, dropped or shifted, or the output enable turns over at the wrong place. A bench that logs every bit at the rising debug-clock edge and compares it with a stream built from R1 to R9 sees this before `done`. Wrong acknowledge or parity bookkeeping shows only in `status` and `rdata` at the `done` pulse. For that reason every acknowledge pattern is swept for both directions.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;
  typedef enum logic [2:0] {
    ST_OK = 3'd0, ST_WAIT = 3'd1, ST_FAULT = 3'd2, ST_PROTO = 3'd3, ST_PARITY = 3'd4
  } swdStatus_t;

  typedef enum logic [3:0] {
    PH_IDLE, PH_INIT, PH_HDR, PH_TRN1, PH_ACK, PH_TRNW, PH_RDATA,
    PH_RPAR, PH_TRN2, PH_WDATA, PH_WPAR, PH_TAIL
  } swdPhase_t;

  typedef struct packed {
    logic load;
    logic ackSample;
    logic rdSample;
    logic parSample;
    logic wrShift;
    logic finish;
  } swdStrobe_t;

  localparam int BURST_LEN   = 64;
  localparam int SWITCH_LEN  = 16;
  localparam logic [15:0] SWITCH_CODE = 16'h79E7;
  localparam int INIT_LEN    = 5 * BURST_LEN + SWITCH_LEN;
  localparam int HDR_LEN     = 8;
  localparam int ACK_LEN     = 3;
  localparam int DATA_LEN    = 32;
  localparam int RD_TAIL_LEN = 16;
  localparam int WR_TAIL_LEN = 15;
endpackage

// File: rtl/swd_host_ctrl.sv
module swd_host_ctrl
  import swd_host_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdInit,
  input  logic       cmdRnw,
  input  logic       cmdIgnoreAck,
  input  logic       swdioIn,
  input  logic [2:0] ackSh,
  input  logic [7:0] hdrBits,
  input  logic       wrBit,
  input  logic       wrPar,
  output swdStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       swclk,
  output logic       swdioOut,
  output logic       swdioOe
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int IDX_W = $clog2(INIT_LEN);

  swdPhase_t        phase, nextPhase;
  logic [IDX_W-1:0] bitIdx;
  logic [DIV_W-1:0] divCnt;
  logic             rnwR, ignR;
  logic             bitEnd, lastBit, halfEnd;
  logic [2:0]       ackFull;

  function automatic int phaseLen(input swdPhase_t ph, input logic rd);
    case (ph)
      PH_INIT:            phaseLen = INIT_LEN;
      PH_HDR:             phaseLen = HDR_LEN;
      PH_ACK:             phaseLen = ACK_LEN;
      PH_RDATA, PH_WDATA: phaseLen = DATA_LEN;
      PH_TAIL:            phaseLen = rd ? RD_TAIL_LEN : WR_TAIL_LEN;
      default:            phaseLen = 1;
    endcase
  endfunction

  function automatic logic initBit(input logic [IDX_W-1:0] k);
    int idx;
    idx = int'(k);
    if (idx < BURST_LEN)                             initBit = 1'b1;
    else if (idx < 2 * BURST_LEN)                    initBit = 1'b0;
    else if (idx < 3 * BURST_LEN)                    initBit = 1'b1;
    else if (idx < 3 * BURST_LEN + SWITCH_LEN)
      initBit = SWITCH_CODE[4'(3 * BURST_LEN + SWITCH_LEN - 1 - idx)];
    else if (idx < 4 * BURST_LEN + SWITCH_LEN)       initBit = 1'b1;
    else                                             initBit = 1'b0;
  endfunction

  assign busy    = (phase != PH_IDLE);
  assign halfEnd = (divCnt == DIV_W'(HALF_DIV - 1));
  assign bitEnd  = busy && swclk && halfEnd;
  assign lastBit = (int'(bitIdx) == phaseLen(phase, rnwR) - 1);
  assign ackFull = {swdioIn, ackSh[2:1]};

  always_comb begin
    nextPhase = phase;
    case (phase)
      PH_INIT:  nextPhase = PH_IDLE;
      PH_HDR:   nextPhase = PH_TRN1;
      PH_TRN1:  nextPhase = PH_ACK;
      PH_ACK:   nextPhase = rnwR ? ((ackFull == 3'b001) ? PH_RDATA : PH_TRN2) : PH_TRNW;
      PH_TRNW:  nextPhase = ((ackSh == 3'b001) || ignR) ? PH_WDATA : PH_TAIL;
      PH_RDATA: nextPhase = PH_RPAR;
      PH_RPAR:  nextPhase = PH_TRN2;
      PH_TRN2:  nextPhase = PH_TAIL;
      PH_WDATA: nextPhase = PH_WPAR;
      PH_WPAR:  nextPhase = PH_TAIL;
      PH_TAIL:  nextPhase = PH_IDLE;
      default:  nextPhase = PH_IDLE;
    endcase
  end

  always_comb begin
    strobe           = '0;
    strobe.load      = !busy && cmdValid;
    strobe.ackSample = bitEnd && (phase == PH_ACK);
    strobe.rdSample  = bitEnd && (phase == PH_RDATA);
    strobe.parSample = bitEnd && (phase == PH_RPAR);
    strobe.wrShift   = bitEnd && (phase == PH_WDATA);
    strobe.finish    = bitEnd && lastBit && ((phase == PH_TAIL) || (phase == PH_INIT));
  end

  always_comb begin
    swdioOe  = 1'b1;
    swdioOut = 1'b0;
    case (phase)
      PH_INIT:  swdioOut = initBit(bitIdx);
      PH_HDR:   swdioOut = hdrBits[bitIdx[2:0]];
      PH_WDATA: swdioOut = wrBit;
      PH_WPAR:  swdioOut = wrPar;
      PH_TRN1, PH_ACK, PH_TRNW, PH_RDATA, PH_RPAR, PH_TRN2: swdioOe = 1'b0;
      default:  swdioOut = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      bitIdx <= '0;
      divCnt <= '0;
      swclk  <= 1'b0;
      done   <= 1'b0;
      rnwR   <= 1'b0;
      ignR   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (cmdValid) begin
          phase  <= cmdInit ? PH_INIT : PH_HDR;
          rnwR   <= cmdRnw;
          ignR   <= cmdIgnoreAck && !cmdRnw;
          bitIdx <= '0;
          divCnt <= '0;
          swclk  <= 1'b0;
        end
      end else if (halfEnd) begin
        divCnt <= '0;
        swclk  <= !swclk;
        if (swclk) begin
          if (lastBit) begin
            phase  <= nextPhase;
            bitIdx <= '0;
            if (nextPhase == PH_IDLE) done <= 1'b1;
          end else begin
            bitIdx <= IDX_W'(bitIdx + 1'b1);
          end
        end
      end else begin
        divCnt <= DIV_W'(divCnt + 1'b1);
      end
    end
  end
endmodule

// File: rtl/swd_host_dp.sv
module swd_host_dp
  import swd_host_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  swdStrobe_t  strobe,
  input  logic        cmdInit,
  input  logic        cmdApNdp,
  input  logic        cmdRnw,
  input  logic [1:0]  cmdAddr,
  input  logic [31:0] cmdWdata,
  input  logic        cmdIgnoreAck,
  input  logic        swdioIn,
  output logic [7:0]  hdrBits,
  output logic        wrBit,
  output logic        wrPar,
  output logic [2:0]  ackSh,
  output logic [31:0] rdata,
  output swdStatus_t  status
);
  logic [31:0] wrSh, rdSh;
  logic        parErr, modeInit, modeRnw, modeIgn;
  swdStatus_t  ackCode, finalCode;

  assign wrBit = wrSh[0];

  always_comb begin
    case (ackSh)
      3'b001:  ackCode = ST_OK;
      3'b010:  ackCode = ST_WAIT;
      3'b100:  ackCode = ST_FAULT;
      default: ackCode = ST_PROTO;
    endcase
    if (modeInit || modeIgn)       finalCode = ST_OK;
    else if (ackCode != ST_OK)     finalCode = ackCode;
    else if (modeRnw && parErr)    finalCode = ST_PARITY;
    else                           finalCode = ST_OK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrBits  <= '0;
      wrSh     <= '0;
      wrPar    <= 1'b0;
      ackSh    <= '0;
      rdSh     <= '0;
      parErr   <= 1'b0;
      modeInit <= 1'b0;
      modeRnw  <= 1'b0;
      modeIgn  <= 1'b0;
      rdata    <= '0;
      status   <= ST_OK;
    end else begin
      if (strobe.load) begin
        hdrBits  <= {1'b1, 1'b0, cmdApNdp ^ cmdRnw ^ cmdAddr[0] ^ cmdAddr[1],
                     cmdAddr[1], cmdAddr[0], cmdRnw, cmdApNdp, 1'b1};
        wrSh     <= cmdWdata;
        wrPar    <= ^cmdWdata;
        ackSh    <= '0;
        rdSh     <= '0;
        parErr   <= 1'b0;
        modeInit <= cmdInit;
        modeRnw  <= cmdRnw;
        modeIgn  <= cmdIgnoreAck && !cmdRnw;
      end
      if (strobe.ackSample) ackSh <= {swdioIn, ackSh[2:1]};
      if (strobe.rdSample)  rdSh  <= {swdioIn, rdSh[31:1]};
      if (strobe.parSample) parErr <= (^rdSh) != swdioIn;
      if (strobe.wrShift)   wrSh  <= {1'b0, wrSh[31:1]};
      if (strobe.finish) begin
        status <= finalCode;
        if (!modeInit && modeRnw) rdata <= rdSh;
      end
    end
  end
endmodule

// File: rtl/swd_host.sv
module swd_host
  import swd_host_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        cmdInit,
  input  logic        cmdApNdp,
  input  logic        cmdRnw,
  input  logic [1:0]  cmdAddr,
  input  logic [31:0] cmdWdata,
  input  logic        cmdIgnoreAck,
  output logic        busy,
  output logic        done,
  output logic [31:0] rdata,
  output logic [2:0]  status,
  output logic        swclk,
  output logic        swdioOut,
  output logic        swdioOe,
  input  logic        swdioIn
);
  swdStrobe_t strobe;
  logic [7:0] hdrBits;
  logic [2:0] ackSh;
  logic       wrBit, wrPar;
  swdStatus_t statusE;

  assign status = statusE;

  swd_host_ctrl #(.HALF_DIV(HALF_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdInit(cmdInit),
    .cmdRnw(cmdRnw), .cmdIgnoreAck(cmdIgnoreAck), .swdioIn(swdioIn),
    .ackSh(ackSh), .hdrBits(hdrBits), .wrBit(wrBit), .wrPar(wrPar),
    .strobe(strobe), .busy(busy), .done(done), .swclk(swclk),
    .swdioOut(swdioOut), .swdioOe(swdioOe)
  );

  swd_host_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdInit(cmdInit),
    .cmdApNdp(cmdApNdp), .cmdRnw(cmdRnw), .cmdAddr(cmdAddr),
    .cmdWdata(cmdWdata), .cmdIgnoreAck(cmdIgnoreAck), .swdioIn(swdioIn),
    .hdrBits(hdrBits), .wrBit(wrBit), .wrPar(wrPar), .ackSh(ackSh),
    .rdata(rdata), .status(statusE)
  );
endmodule

// File: rtl/swd_host_chk.sv
module swd_host_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        done,
  input logic [31:0] rdata,
  input logic [2:0]  status,
  input logic        swclk,
  input logic        swdioOut,
  input logic        swdioOe
);
  a_r3_stable_while_high: assert property (@(posedge clk) disable iff (!rstN)
    (swclk && $past(swclk)) |-> ($stable(swdioOut) && $stable(swdioOe)));
  a_r3_clock_low_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !swclk);
  a_r4_status_legal: assert property (@(posedge clk) disable iff (!rstN)
    status <= 3'd4);
  a_r9_driven_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> swdioOe);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r11_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> ($stable(status) && $stable(rdata)));
endmodule

bind swd_host swd_host_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .rdata(rdata),
  .status(status), .swclk(swclk), .swdioOut(swdioOut), .swdioOe(swdioOe)
);

// File: tb/swd_host_tb.sv
module swd_host_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int MAXB = 400;

  logic clk = 0, rstN = 0;
  logic cmdValid = 0, cmdInit = 0, cmdApNdp = 0, cmdRnw = 0, cmdIgnoreAck = 0;
  logic [1:0] cmdAddr = 0;
  logic [31:0] cmdWdata = 0;
  logic busy, done, swclk, swdioOut, swdioOe, swdioIn;
  logic [31:0] rdata;
  logic [2:0] status;
  logic tgt = 0;

  int testCnt = 0, failCnt = 0;
  logic expOut [MAXB], expOe [MAXB], resp [MAXB], actOut [MAXB], actOe [MAXB];
  int expN, bitK = 0, txnSeq = 0, seenSeq = 0, hiCnt = 0, perErr = 0;
  logic [2:0] expStatus;
  logic [31:0] expRdata = 0;

  always #(CLK_PERIOD / 2) clk = !clk;
  assign swdioIn = swdioOe ? swdioOut : tgt;

  swd_host #(.HALF_DIV(HALF)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdInit(cmdInit),
    .cmdApNdp(cmdApNdp), .cmdRnw(cmdRnw), .cmdAddr(cmdAddr),
    .cmdWdata(cmdWdata), .cmdIgnoreAck(cmdIgnoreAck), .busy(busy),
    .done(done), .rdata(rdata), .status(status), .swclk(swclk),
    .swdioOut(swdioOut), .swdioOe(swdioOe), .swdioIn(swdioIn)
  );

  // target model: logs each host bit, drives its reply from the rising edge
  always @(posedge swclk) begin
    if (txnSeq != seenSeq) begin bitK = 0; seenSeq = txnSeq; end
    if (bitK < MAXB) begin
      actOut[bitK] = swdioOut;
      actOe[bitK]  = swdioOe;
      tgt          = resp[bitK];
    end
    bitK++;
  end

  // R3: high phase length
  always @(negedge clk) begin
    if (swclk) hiCnt++;
    else if (hiCnt != 0) begin
      if (hiCnt != HALF) perErr++;
      hiCnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic v, input logic oe, input logic r);
    expOut[expN] = v; expOe[expN] = oe; resp[expN] = r; expN++;
  endtask

  task automatic build(input bit init, input bit ap, input bit rnw, input logic [1:0] addr,
                       input logic [31:0] wd, input bit ign, input logic [2:0] ack,
                       input logic [31:0] rd, input bit badPar);
    bit ok;
    logic [15:0] sw;
    expN = 0;
    sw = 16'h79E7;
    ok = (ack == 3'b001);
    for (int i = 0; i < MAXB; i++) resp[i] = 0;
    if (init) begin
      for (int i = 0; i < 64; i++) push(1, 1, 0);
      for (int i = 0; i < 64; i++) push(0, 1, 0);
      for (int i = 0; i < 64; i++) push(1, 1, 0);
      for (int i = 15; i >= 0; i--) push(sw[i], 1, 0);
      for (int i = 0; i < 64; i++) push(1, 1, 0);
      for (int i = 0; i < 64; i++) push(0, 1, 0);
      expStatus = 0;
      return;
    end
    push(1, 1, 0); push(ap, 1, 0); push(rnw, 1, 0); push(addr[0], 1, 0);
    push(addr[1], 1, 0); push(ap ^ rnw ^ addr[0] ^ addr[1], 1, 0); push(0, 1, 0); push(1, 1, 0);
    push(0, 0, 0);
    for (int i = 0; i < 3; i++) push(0, 0, ack[i]);
    if (rnw) begin
      if (ok) begin
        for (int i = 0; i < 32; i++) push(0, 0, rd[i]);
        push(0, 0, (^rd) ^ badPar);
      end
      push(0, 0, 0);
      for (int i = 0; i < 16; i++) push(0, 1, 0);
      expRdata = ok ? rd : 32'h0;
    end else begin
      push(0, 0, 0);
      if (ok || ign) begin
        for (int i = 0; i < 32; i++) push(wd[i], 1, 0);
        push(^wd, 1, 0);
      end
      for (int i = 0; i < 15; i++) push(0, 1, 0);
    end
    if (!rnw && ign) expStatus = 0;
    else if (ack == 3'b001) expStatus = (rnw && badPar) ? 3'd4 : 3'd0;
    else if (ack == 3'b010) expStatus = 1;
    else if (ack == 3'b100) expStatus = 2;
    else expStatus = 3;
  endtask

  task automatic issue(input bit init, input bit ap, input bit rnw, input logic [1:0] addr,
                       input logic [31:0] wd, input bit ign);
    @(negedge clk);
    txnSeq++;
    cmdValid = 1; cmdInit = init; cmdApNdp = ap; cmdRnw = rnw; cmdAddr = addr;
    cmdWdata = wd; cmdIgnoreAck = ign;
    @(negedge clk);
    cmdValid = 0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  task automatic checkStream(input string req);
    int bad;
    bad = -1;
    for (int i = 0; i < expN && i < MAXB; i++)
      if (bad < 0 && (actOe[i] !== expOe[i] || (expOe[i] && actOut[i] !== expOut[i]))) bad = i;
    chk(bitK == expN, {req, " bit count"}, bitK, expN);
    if (bad >= 0) chk(0, {req, " stream bit"}, {actOe[bad], actOut[bad]}, {expOe[bad], expOut[bad]});
    else chk(1, req, 0, 0);
  endtask

  task automatic runTxn(input bit init, input bit ap, input bit rnw, input logic [1:0] addr,
                        input logic [31:0] wd, input bit ign, input logic [2:0] ack,
                        input logic [31:0] rd, input bit badPar, input string req);
    build(init, ap, rnw, addr, wd, ign, ack, rd, badPar);
    issue(init, ap, rnw, addr, wd, ign);
    waitDone();
    checkStream(req);
    chk(status == expStatus, {req, " status"}, status, expStatus);
    chk(rdata == expRdata, {req, " rdata"}, rdata, expRdata);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy && !done && !swclk && !swdioOut && swdioOe && status == 0, "R12 reset",
        {busy, done, swclk, swdioOut, swdioOe, status}, 8'b00001000);
    rstN = 1;
    repeat (2) @(negedge clk);

    runTxn(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1 init sequence");

    // R2 R5 R6 R7: all header combinations with an OK reply
    for (int c = 0; c < 16; c++) begin
      logic [31:0] v;
      v = 32'h9E3779B9 * (c + 1);
      runTxn(0, c[3], c[2], c[1:0], v, 0, 3'b001, ~v, 0, c[2] ? "R2 R5 R6 read" : "R2 R7 write");
    end

    // R4: every acknowledge pattern, both directions
    for (int a = 0; a < 8; a++) begin
      runTxn(0, 1, 1, 2'd1, 0, 0, 3'(a), 32'h0F0F_1234 + a, 0, "R4 R6 read ack");
      runTxn(0, 0, 0, 2'd3, 32'hA5A5_0000 + a, 0, 3'(a), 0, 0, "R4 R7 write ack");
    end

    // R8: ignore option on writes and on a read
    runTxn(0, 1, 0, 2'd2, 32'hDEAD_BEEF, 1, 3'b100, 0, 0, "R8 ignore fault");
    runTxn(0, 0, 0, 2'd0, 32'h0000_0001, 1, 3'b111, 0, 0, "R8 ignore proto");
    runTxn(0, 0, 1, 2'd0, 0, 1, 3'b010, 32'h1, 0, "R8 read ignore no effect");

    // R5: parity error, and all-ones / all-zero data
    runTxn(0, 1, 1, 2'd3, 0, 0, 3'b001, 32'h8000_0001, 1, "R5 parity error");
    runTxn(0, 0, 1, 2'd2, 0, 0, 3'b001, 32'hFFFF_FFFF, 0, "R5 all ones");
    runTxn(0, 0, 1, 2'd2, 0, 0, 3'b001, 32'h0, 0, "R5 all zero");

    // R10: a command offered while busy is ignored
    build(0, 0, 0, 2'd1, 32'h1357_9BDF, 0, 3'b001, 0, 0);
    issue(0, 0, 0, 2'd1, 32'h1357_9BDF, 0);
    chk(busy, "R10 busy after accept", busy, 1);
    repeat (40) @(negedge clk);
    cmdValid = 1; cmdInit = 1; cmdRnw = 1;
    @(negedge clk);
    cmdValid = 0; cmdInit = 0;
    waitDone();
    chk(!busy, "R10 busy low at done", busy, 0);
    checkStream("R10 blocked command");
    chk(status == 0, "R10 status", status, 0);
    @(negedge clk);
    chk(!done, "R10 done one cycle", done, 0);
    repeat (60) @(negedge clk);
    chk(!busy && bitK == expN, "R10 no late start", bitK, expN);

    // R11: hold after a read
    runTxn(0, 1, 1, 2'd0, 0, 0, 3'b001, 32'hCAFE_F00D, 1, "R11 read");
    repeat (100) @(negedge clk);
    chk(rdata == 32'hCAFE_F00D && status == 4, "R11 hold", {status, rdata}, {3'd4, 32'hCAFE_F00D});

    chk(perErr == 0, "R3 clock high length", perErr, 0);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule